// File: doc/BRIEF.md
# Pointer-Indexed Sequential RAM Access Port

This block lets an 8-bit host bus reach a 2048 x 8 on-chip buffer RAM without mapping the RAM into host address space. The host sets an 11-bit address through two pointer registers: first the upper byte, then the lower byte. It then moves data one byte at a time through a single data register.

Writing the lower pointer byte loads the address. The block then fetches that location into the data register in the background. A busy flag shows when the fetch is still under way. Two control bits in the upper pointer register set the transfer direction and turn auto-increment on or off. With auto-increment on, each data access moves the address forward by one and fetches the next byte ahead. The host can then stream a whole packet in or out without reloading the pointer.

Top module: `ptr_ram_port`

## Requirements
- R1: After reset the address counter is 000h, both control bits are 0 (read direction, no auto-increment), the data register holds 00h and busy_o is low.
- R2: A write to offset 2 stores bit 7 as the direction (1 = host writes RAM), bit 6 as auto-increment enable and bits 2:0 as staged address bits 10:8. It does not change the counter and does not start a fetch, so busy_o stays low.
- R3: A write to offset 3 loads the counter with {staged bits 10:8, written byte}.
- R4: Every fetch trigger (a low-pointer write or an accepted data access) raises busy_o for the two following cycles. When busy_o falls, the data register (read at offset 4) holds the RAM byte at the current counter.
- R5: With direction = 1, a write to offset 4 stores the byte at the current address. The following fetch shows that byte in the data register.
- R6: With auto-increment on, an accepted data access (a read in read direction, a write in write direction) advances the counter by one, and the following fetch returns the byte at the new address.
- R7: With auto-increment off, data accesses leave the counter unchanged, and repeated reads return the same byte.
- R8: The counter wraps from 7FFh to 000h when it advances.
- R9: Reading offset 2 returns {direction, auto-increment, 000, counter bits 10:8}, and reading offset 3 returns counter bits 7:0. Offsets 0, 1, 5, 6 and 7 read as 00h, and writes to them change nothing.
- R10: A data register access that does not match the direction is ignored. In read direction a write to offset 4 stores nothing and does not advance the counter. In write direction a read of offset 4 does not advance the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_i | input | 1 | Chip select for host accesses |
| rd_i | input | 1 | Host read strobe, one cycle per access |
| wr_i | input | 1 | Host write strobe, one cycle per access |
| addr_i | input | 3 | Register offset |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Host read data; 00h when no read is selected |
| busy_o | output | 1 | High while a fetch into the data register is pending |

## Verification
The full RAM is first filled through the write path in auto-increment mode with an address-dependent pattern. It is then streamed back in read mode. This separates a counter that skips or repeats a step from a fetch that returns stale data, and both runs end by crossing 7FFh, which shows the wrap. Short runs at fixed addresses with auto-increment off show that the counter holds, that a single written byte comes back, and that an access in the wrong direction changes neither the counter nor the RAM. Writes to unmapped offsets and to the high pointer alone are followed by readback of both pointer bytes and of busy_o. This shows that the staged bits do not reach the counter before the low byte is written.

// File: rtl/ptr_ram_pkg.sv
package ptr_ram_pkg;
  localparam int OFS_W = 3;
  localparam logic [OFS_W-1:0] OFS_PTR_HI = 3'd2;
  localparam logic [OFS_W-1:0] OFS_PTR_LO = 3'd3;
  localparam logic [OFS_W-1:0] OFS_DATA   = 3'd4;
  localparam int DIR_BIT = 7;
  localparam int AI_BIT  = 6;
endpackage

// File: rtl/ptr_ram_mem.sv
module ptr_ram_mem #(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] waddr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              re_i,
  input  logic [ADDR_W-1:0] raddr_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
    if (re_i) rdata_o <= mem_q[raddr_i];
  end
endmodule

// File: rtl/ptr_ram_cnt.sv
module ptr_ram_cnt #(
  parameter int ADDR_W = 11
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] load_val_i,
  input  logic              inc_i,
  output logic [ADDR_W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_o <= '0;
    else if (load_i) cnt_o <= load_val_i;
    else if (inc_i)  cnt_o <= cnt_o + 1'b1;
  end

  AST_CNT_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_o == $past(load_val_i)); // R3
  AST_CNT_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (inc_i && !load_i && (&cnt_o)) |=> cnt_o == '0); // R8
  AST_CNT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!inc_i && !load_i) |=> $stable(cnt_o)); // R7
endmodule

// File: rtl/ptr_ram_port.sv
module ptr_ram_port
  import ptr_ram_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [OFS_W-1:0]  addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              busy_o
);
  localparam int HI_W  = ADDR_W - DATA_W;
  localparam int PAD_W = DATA_W - 2 - HI_W;

  logic hi_wr, lo_wr, dat_rd, dat_wr, acc, inc, trig, mem_we;
  logic dir_q, ai_q;
  logic [HI_W-1:0]   hi_q;
  logic [ADDR_W-1:0] cnt;
  logic [DATA_W-1:0] mem_rd, data_q;
  logic pf_req_q, pf_rd_q;

  assign hi_wr  = cs_i && wr_i && (addr_i == OFS_PTR_HI);
  assign lo_wr  = cs_i && wr_i && (addr_i == OFS_PTR_LO);
  assign dat_rd = cs_i && rd_i && (addr_i == OFS_DATA);
  assign dat_wr = cs_i && wr_i && (addr_i == OFS_DATA);
  // only the access matching the direction is accepted
  assign acc    = (dat_rd && !dir_q) || (dat_wr && dir_q);
  assign mem_we = dat_wr && dir_q;
  assign inc    = acc && ai_q;
  assign trig   = lo_wr || acc;
  assign busy_o = pf_req_q || pf_rd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q <= 1'b0;
      ai_q  <= 1'b0;
      hi_q  <= '0;
    end else if (hi_wr) begin
      dir_q <= wdata_i[DIR_BIT];
      ai_q  <= wdata_i[AI_BIT];
      hi_q  <= wdata_i[HI_W-1:0];
    end
  end

  // fetch pipeline: counter settles, RAM read, data register load
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pf_req_q <= 1'b0;
      pf_rd_q  <= 1'b0;
      data_q   <= '0;
    end else begin
      pf_req_q <= trig;
      pf_rd_q  <= pf_req_q;
      if (pf_rd_q) data_q <= mem_rd;
    end
  end

  ptr_ram_cnt #(.ADDR_W(ADDR_W)) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (lo_wr),
    .load_val_i ({hi_q, wdata_i}),
    .inc_i      (inc),
    .cnt_o      (cnt)
  );

  ptr_ram_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk_i   (clk_i),
    .we_i    (mem_we),
    .waddr_i (cnt),
    .wdata_i (wdata_i),
    .re_i    (pf_req_q),
    .raddr_i (cnt),
    .rdata_o (mem_rd)
  );

  always_comb begin
    rdata_o = '0;
    if (cs_i && rd_i) begin
      unique case (addr_i)
        OFS_PTR_HI: rdata_o = {dir_q, ai_q, {PAD_W{1'b0}}, cnt[ADDR_W-1:DATA_W]};
        OFS_PTR_LO: rdata_o = cnt[DATA_W-1:0];
        OFS_DATA:   rdata_o = data_q;
        default:    rdata_o = '0;
      endcase
    end
  end

  AST_TRIG_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trig |=> busy_o); // R4
  AST_PF_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pf_rd_q && !pf_req_q && !trig) |=> !busy_o); // R4
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |=> $stable(data_q)); // R4
  AST_HI_NO_FETCH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hi_wr && !busy_o) |=> !busy_o); // R2
  AST_HI_NO_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hi_wr |=> $stable(cnt)); // R2
  AST_NO_WRONG_DIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr && !dir_q) |=> ($stable(cnt) && !busy_o)); // R10
endmodule

// File: tb/ptr_ram_port_bench.sv
module ptr_ram_port_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
  logic [2:0] addr = '0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       busy;
  int checks = 0, fails = 0, cycles = 0;

  always #2.5 clk = ~clk;

  ptr_ram_port u_ptr_ram_port (
    .clk_i(clk), .rst_ni(rst_n), .cs_i(cs), .rd_i(rd), .wr_i(wr),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .busy_o(busy)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  function automatic logic [7:0] pat(int a);
    return 8'((a * 37) + ((a >> 8) * 11) + 5);
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic host_wr(logic [2:0] ofs, logic [7:0] d);
    @(negedge clk);
    cs = 1; wr = 1; addr = ofs; wdata = d;
    @(negedge clk);
    cs = 0; wr = 0;
    wait_idle();
  endtask

  task automatic host_rd(logic [2:0] ofs, output logic [7:0] d);
    @(negedge clk);
    cs = 1; rd = 1; addr = ofs;
    #1 d = rdata;
    @(negedge clk);
    cs = 0; rd = 0;
    wait_idle();
  endtask

  task automatic rd_ptr(output int a, output logic [7:0] hi);
    logic [7:0] lo;
    host_rd(3'd2, hi);
    host_rd(3'd3, lo);
    a = {hi[2:0], lo};
  endtask

  task automatic t_reset();
    logic [7:0] v; int a;
    chk("R1 busy", busy, 0);
    rd_ptr(a, v);
    chk("R1 ctrl", v, 8'h00);
    chk("R1 counter", a, 0);
    host_rd(3'd4, v);
    chk("R1 data", v, 8'h00);
  endtask

  task automatic t_hi_stage();
    logic [7:0] v; int a;
    @(negedge clk);
    cs = 1; wr = 1; addr = 3'd2; wdata = 8'h45;
    @(negedge clk);
    cs = 0; wr = 0;
    chk("R2 no fetch after hi write", busy, 0);
    @(negedge clk);
    chk("R2 still idle", busy, 0);
    rd_ptr(a, v);
    chk("R2 ctrl bits", v[7:6], 2'b01);
    chk("R2 counter not loaded", a, 0);
    @(negedge clk);
    cs = 1; wr = 1; addr = 3'd3; wdata = 8'h9C;
    @(negedge clk);
    cs = 0; wr = 0;
    chk("R4 busy after trigger", busy, 1);
    @(negedge clk);
    chk("R4 busy second cycle", busy, 1);
    @(negedge clk);
    chk("R4 busy cleared", busy, 0);
    rd_ptr(a, v);
    chk("R3 low write loads", a, 12'h59C & 11'h7FF);
  endtask

  task automatic t_fill();
    int a; logic [7:0] v;
    host_wr(3'd2, 8'hC0);
    host_wr(3'd3, 8'h00);
    for (int i = 0; i < 2048; i++) host_wr(3'd4, pat(i));
    rd_ptr(a, v);
    chk("R8 wrap after fill", a, 0);
  endtask

  task automatic t_stream();
    logic [7:0] v; int a;
    host_wr(3'd2, 8'h40);
    host_wr(3'd3, 8'h00);
    for (int i = 0; i < 2048; i++) begin
      host_rd(3'd4, v);
      chk("R6 R5 stream byte", v, pat(i));
    end
    rd_ptr(a, v);
    chk("R8 wrap after stream", a, 0);
    host_rd(3'd4, v);
    chk("R8 fetch at 000 after wrap", v, pat(0));
  endtask

  task automatic t_wrap();
    logic [7:0] v; int a;
    host_wr(3'd2, 8'h47);
    host_wr(3'd3, 8'hFE);
    host_rd(3'd4, v);
    chk("R6 byte 7FE", v, pat(12'h7FE));
    host_rd(3'd4, v);
    chk("R8 byte 7FF", v, pat(12'h7FF));
    rd_ptr(a, v);
    chk("R8 counter wrapped", a, 0);
    host_rd(3'd4, v);
    chk("R8 byte 000", v, pat(0));
  endtask

  task automatic t_no_inc();
    logic [7:0] v; int a;
    host_wr(3'd2, 8'h01);
    host_wr(3'd3, 8'h23);
    for (int k = 0; k < 3; k++) begin
      host_rd(3'd4, v);
      chk("R7 repeated read", v, pat(12'h123));
    end
    rd_ptr(a, v);
    chk("R7 counter held", a, 12'h123);
    host_wr(3'd2, 8'h81);
    host_wr(3'd3, 8'h23);
    host_wr(3'd4, 8'hA5);
    rd_ptr(a, v);
    chk("R7 counter held on write", a, 12'h123);
    host_rd(3'd4, v);
    chk("R5 written byte fetched", v, 8'hA5);
  endtask

  task automatic t_wrong_dir();
    logic [7:0] v; int a;
    host_wr(3'd2, 8'h42);
    host_wr(3'd3, 8'h10);
    @(negedge clk);
    cs = 1; wr = 1; addr = 3'd4; wdata = 8'h5A;
    @(negedge clk);
    cs = 0; wr = 0;
    chk("R10 no fetch on ignored write", busy, 0);
    rd_ptr(a, v);
    chk("R10 counter held read dir", a, 12'h210);
    host_rd(3'd4, v);
    chk("R10 RAM unchanged", v, pat(12'h210));
    host_wr(3'd2, 8'hC2);
    host_wr(3'd3, 8'h20);
    host_rd(3'd4, v);
    rd_ptr(a, v);
    chk("R10 counter held write dir", a, 12'h220);
  endtask

  task automatic t_unmapped();
    logic [7:0] v; int a;
    host_wr(3'd2, 8'h03);
    host_wr(3'd3, 8'h77);
    foreach (a_list[j]) host_wr(a_list[j], 8'hFF);
    foreach (a_list[j]) begin
      host_rd(a_list[j], v);
      chk("R9 unmapped reads zero", v, 0);
    end
    rd_ptr(a, v);
    chk("R9 ctrl readback", v, 8'h03);
    chk("R9 counter unchanged", a, 12'h377);
    host_rd(3'd4, v);
    chk("R9 data unchanged", v, pat(12'h377));
  endtask

  logic [2:0] a_list [5] = '{3'd0, 3'd1, 3'd5, 3'd6, 3'd7};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_hi_stage();
    t_fill();
    t_stream();
    t_wrap();
    t_no_inc();
    t_wrong_dir();
    t_unmapped();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule